// File: doc/BRIEF.md
# Sector Erase Collection Window

This block sits on the device side of an erase controller. It gathers sector erase requests into one batch before the erase begins. The first accepted sector request opens an acceptance window of programmable length. Each later sector request that arrives while the window is open adds its sector to the batch and restarts the full window. When the window runs out without a new request, the block closes the batch. It raises the window-closed status bit and issues a single erase-start pulse.

While the batch is closed, the block ignores every erase command except a suspend request, which it forwards. This lasts until the external erase engine reports completion. A whole-device erase request does not wait for a window. It starts at once with every sector selected, and the window-closed bit stays low. The cell erase itself is outside the block and is represented by the `done_in` input.

Commands arrive as single-cycle decoded pulses. The window length is counted in clock cycles. The default is 2500 cycles, which is 50 µs at a 50 MHz clock.

Top module: `erase_gather_top`

## Requirements
- R1: In the cycle after reset, `sel_mask` is all zero and `win_closed`, `start_pulse` and `susp_pulse` are 0.
- R2: A sector request (`sec_req`) accepted while idle or while the window is open sets bit `sec_idx` of `sel_mask` (bit position equals the sector index) on the next cycle, and `win_closed` stays 0.
- R3: `win_closed` rises exactly `WIN_CYCLES` clock cycles after the edge that accepted the most recent sector request. Every accepted sector request restarts this count.
- R4: `start_pulse` is high for exactly one cycle, in the same cycle in which `win_closed` rises, or in the cycle after a whole-device request is accepted.
- R5: While `win_closed` is 1, sector and whole-device requests are ignored: `sel_mask` is unchanged and no `start_pulse` occurs.
- R6: A whole-device request (`chip_req`) accepted while idle or while the window is open sets `sel_mask` to all ones and pulses `start_pulse` on the next cycle. `win_closed` stays 0, and later requests are ignored until `done_in`.
- R7: A suspend request (`susp_req`) while an erase is running (batch closed or whole-device erase) gives a one-cycle `susp_pulse` on the next cycle without changing `sel_mask` or `win_closed`. At any other time `susp_req` gives no pulse.
- R8: `done_in` while an erase is running clears `sel_mask` and `win_closed` on the next cycle and returns the block to idle. At any other time `done_in` has no effect.
- R9: When `chip_req` and `sec_req` arrive in the same cycle, the whole-device request wins: the mask becomes all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_req | input | 1 | One-cycle sector erase request |
| sec_idx | input | 5 | Sector index for `sec_req` |
| chip_req | input | 1 | One-cycle whole-device erase request |
| susp_req | input | 1 | One-cycle erase suspend request |
| done_in | input | 1 | Erase engine reports completion |
| sel_mask | output | 32 | Selected sectors, bit n = sector n |
| start_pulse | output | 1 | One-cycle erase start |
| win_closed | output | 1 | 1 once the acceptance window has expired |
| susp_pulse | output | 1 | Forwarded suspend, one cycle |

## Verification
The hardest case to reach is the exact expiry edge after several restarts. A request that lands one cycle before expiry must extend the window. One that lands one cycle after expiry must be ignored. The stimulus spaces sector requests at gaps just below the window length, then issues requests immediately after closure. It uses a short window so these edges occur within a few dozen cycles. A behavioural model counts cycles since the last accepted request and is compared with every output on every clock.

// File: rtl/erase_gather_pkg.sv
package erase_gather_pkg;

    localparam int unsigned DEF_SECTORS = 32;
    localparam int unsigned DEF_WINDOW  = 2500;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_CLOSED = 2'd2,
        ST_CHIP   = 2'd3
    } gather_state_e;

    function automatic logic is_erasing(input gather_state_e s);
        return (s == ST_CLOSED) || (s == ST_CHIP);
    endfunction

    function automatic logic is_open(input gather_state_e s);
        return (s == ST_IDLE) || (s == ST_GATHER);
    endfunction

endpackage

// File: rtl/erase_window_timer.sv
module erase_window_timer #(
    parameter int unsigned WIN_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic reload,
    input  logic running,
    output logic expire
);
    localparam int unsigned CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (reload)
            cnt_q <= LOAD_VAL;
        else if (running && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = running && !reload && (cnt_q == '0);

    // R3: a reload always leaves a full window ahead
    p_reload_full_r3: assert property (@(posedge clk) disable iff (rst)
        reload |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/erase_sector_mask.sv
module erase_sector_mask #(
    parameter int unsigned SECTORS = 32,
    localparam int unsigned IW = $clog2(SECTORS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_one,
    input  logic [IW-1:0]      set_idx,
    input  logic               set_all,
    input  logic               clear,
    output logic [SECTORS-1:0] mask
);
    for (genvar g = 0; g < SECTORS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clear)
                mask[g] <= 1'b0;
            else if (set_all || (set_one && set_idx == IW'(g)))
                mask[g] <= 1'b1;
        end
    end

    // R5: with no update request the mask holds
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!set_one && !set_all && !clear) |=> $stable(mask));

endmodule

// File: rtl/erase_gather_top.sv
module erase_gather_top
    import erase_gather_pkg::*;
#(
    parameter int unsigned SECTORS    = DEF_SECTORS,
    parameter int unsigned WIN_CYCLES = DEF_WINDOW,
    localparam int unsigned IW = $clog2(SECTORS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sec_req,
    input  logic [IW-1:0]      sec_idx,
    input  logic               chip_req,
    input  logic               susp_req,
    input  logic               done_in,
    output logic [SECTORS-1:0] sel_mask,
    output logic               start_pulse,
    output logic               win_closed,
    output logic               susp_pulse
);
    gather_state_e state_q, state_d;
    logic acc_sec, acc_chip, expire, finish, running;
    logic start_q, susp_q;

    assign acc_chip = chip_req && is_open(state_q);
    assign acc_sec  = sec_req && !chip_req && is_open(state_q);
    assign finish   = done_in && is_erasing(state_q);
    assign running  = (state_q == ST_GATHER);

    erase_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .reload  (acc_sec),
        .running (running),
        .expire  (expire)
    );

    erase_sector_mask #(.SECTORS(SECTORS)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .set_one (acc_sec),
        .set_idx (sec_idx),
        .set_all (acc_chip),
        .clear   (finish),
        .mask    (sel_mask)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_GATHER: begin
                if (acc_chip)     state_d = ST_CHIP;
                else if (acc_sec) state_d = ST_GATHER;
                else if (expire)  state_d = ST_CLOSED;
            end
            ST_CLOSED, ST_CHIP: begin
                if (finish)       state_d = ST_IDLE;
            end
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
            susp_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= acc_chip || (expire && !acc_sec);
            susp_q  <= susp_req && is_erasing(state_q);
        end
    end

    assign start_pulse = start_q;
    assign susp_pulse  = susp_q;
    assign win_closed  = (state_q == ST_CLOSED);

    // R4: start lasts one cycle
    p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R4: closing the window always comes with a start pulse
    p_close_starts_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(win_closed) |-> start_pulse);

    // R3: the window closes only out of the gathering phase
    p_close_from_gather_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(win_closed) |-> ($past(state_q) == ST_GATHER));

    // R8: completion clears the batch
    p_done_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (done_in && is_erasing(state_q)) |=> (sel_mask == '0 && !win_closed));

    // R5: a closed batch keeps its mask until completion
    p_locked_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (win_closed && !done_in) |=> $stable(sel_mask));

    // R7: suspend is forwarded only while erasing
    p_susp_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (susp_req && !is_erasing(state_q)) |=> !susp_pulse);

endmodule

// File: tb/erase_gather_top_test.sv
module erase_gather_top_test;
    localparam int W = 20;

    logic        clk = 0, rst = 1;
    logic        sec_req = 0, chip_req = 0, susp_req = 0, done_in = 0;
    logic [4:0]  sec_idx = 0;
    logic [31:0] sel_mask;
    logic        start_pulse, win_closed, susp_pulse;

    int total = 0, bad = 0;

    erase_gather_top #(.SECTORS(32), .WIN_CYCLES(W)) uut (
        .clk(clk), .rst(rst), .sec_req(sec_req), .sec_idx(sec_idx),
        .chip_req(chip_req), .susp_req(susp_req), .done_in(done_in),
        .sel_mask(sel_mask), .start_pulse(start_pulse),
        .win_closed(win_closed), .susp_pulse(susp_pulse));

    always #5 clk = ~clk;

    // behavioural reference: phase 0 idle, 1 gathering, 2 closed, 3 whole-device
    int          phase = 0, age = 0;
    logic [31:0] m_mask = 0;
    logic        m_start = 0, m_susp = 0;

    always @(posedge clk) begin
        m_start = 0;
        m_susp  = 0;
        if (rst) begin
            phase = 0; age = 0; m_mask = 0;
        end else if (phase <= 1) begin
            if (chip_req) begin
                phase = 3; m_mask = 32'hFFFF_FFFF; m_start = 1;
            end else if (sec_req) begin
                phase = 1; age = 0; m_mask[sec_idx] = 1'b1;
            end else if (phase == 1) begin
                age++;
                if (age == W) begin phase = 2; m_start = 1; end
            end
        end else begin
            if (susp_req) m_susp = 1;
            if (done_in) begin phase = 0; m_mask = 0; end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R2 mask", sel_mask, m_mask);
            chk("R3 closed", {31'b0, win_closed}, {31'b0, phase == 2});
            chk("R4 start", {31'b0, start_pulse}, {31'b0, m_start});
            chk("R7 suspend", {31'b0, susp_pulse}, {31'b0, m_susp});
            sec_req = 0; chip_req = 0; susp_req = 0; done_in = 0;
        end
    endtask

    task automatic sector(input int idx);
        sec_req = 1; sec_idx = 5'(idx);
        tick();
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(2);
        rst = 0;
        tick();
        chk("R1 mask", sel_mask, 0);
        chk("R1 closed", {31'b0, win_closed}, 0);

        // restarts at gaps just under the window
        sector(3);
        chk("R2 bit3", sel_mask, 32'h8);
        tick(W - 2);
        sector(7);
        tick(W - 1);
        sector(31);
        tick(W - 1);
        chk("R3 still open", {31'b0, win_closed}, 0);
        tick();
        chk("R3 closed at W", {31'b0, win_closed}, 1);
        chk("R4 start at close", {31'b0, start_pulse}, 1);

        // lockout
        sector(5);
        chk("R5 sector ignored", sel_mask, 32'h8000_0088);
        chip_req = 1; tick();
        chk("R5 chip ignored", sel_mask, 32'h8000_0088);
        chk("R5 no start", {31'b0, start_pulse}, 0);
        susp_req = 1; tick();
        chk("R7 suspend forwarded", {31'b0, susp_pulse}, 1);
        chk("R7 closed kept", {31'b0, win_closed}, 1);
        tick(3);
        done_in = 1; tick();
        chk("R8 cleared", sel_mask, 0);
        chk("R8 reopened", {31'b0, win_closed}, 0);

        // done and suspend outside an erase
        done_in = 1; susp_req = 1; tick();
        chk("R8 idle done ignored", sel_mask, 0);
        chk("R7 idle suspend", {31'b0, susp_pulse}, 0);

        // whole-device erase from idle
        chip_req = 1; tick();
        chk("R6 all set", sel_mask, 32'hFFFF_FFFF);
        chk("R6 start", {31'b0, start_pulse}, 1);
        chk("R6 no window", {31'b0, win_closed}, 0);
        tick(W + 5);
        chk("R6 stays open bit", {31'b0, win_closed}, 0);
        susp_req = 1; tick();
        chk("R7 chip suspend", {31'b0, susp_pulse}, 1);
        done_in = 1; tick();
        chk("R8 chip done", sel_mask, 0);

        // whole-device request during gathering, and suspend while gathering
        sector(0);
        susp_req = 1; tick();
        chk("R7 gather suspend", {31'b0, susp_pulse}, 0);
        tick(4);
        chip_req = 1; tick();
        chk("R6 from gather", sel_mask, 32'hFFFF_FFFF);
        sector(9);
        chk("R6 locked", sel_mask, 32'hFFFF_FFFF);
        done_in = 1; tick();

        // simultaneous requests
        chip_req = 1; sec_req = 1; sec_idx = 5'd12; tick();
        chk("R9 chip wins", sel_mask, 32'hFFFF_FFFF);
        chk("R9 start", {31'b0, start_pulse}, 1);
        done_in = 1; tick();

        // single request closes after W
        sector(17);
        tick(W - 1);
        chk("R3 single open", {31'b0, win_closed}, 0);
        tick();
        chk("R3 single closed", {31'b0, win_closed}, 1);
        tick();
        chk("R4 start one cycle", {31'b0, start_pulse}, 0);
        sector(18);
        chk("R5 late request", sel_mask, 32'h0002_0000);
        done_in = 1; tick();
        tick(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule